// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the set of active lanes for one 32-wide warp as it runs if/else control flow. Every lane runs every instruction. A lane writes its result back only while its bit in the active mask is 1. Three markers drive the block: a push, a complement and a pop. Each one arrives as a two-bit operation code on the same cycle as its instruction.

On a divergent branch the block saves the current mask on a small hardware stack. It then narrows the mask to the lanes whose predicate bit is set. At the else point it activates the lanes of the other path. Those are the lanes that were active before the branch and whose predicate was clear. At the reconvergence point it pops the stack and restores the mask that was in force before the branch.

Branches nest up to the stack depth. A push with no free entry is refused, and so is a complement or pop with no open branch. Each refused command raises a sticky error flag.

Top module: `simt_div_mask`

## Requirements
- R1: While the synchronous active-high reset is applied, on the next clock edge the active mask becomes all ones, the stack empties and both error flags clear.
- R2: Operation code 2'b01 (push) with a free entry saves the current mask and sets the active mask to the old mask AND the predicate. The result appears on the edge that samples the command.
- R3: A push never makes a lane active that was inactive just before it.
- R4: Operation code 2'b10 (complement) with an open branch sets the active mask to the saved parent mask AND NOT the predicate captured at that branch's push. Issuing it again gives the same mask.
- R5: Operation code 2'b11 (pop) with an open branch restores the parent mask saved by the matching push.
- R6: A predicate that is uniform over the active lanes still pushes an entry. One path then gets an all-zero mask, and the matching pop still restores the parent.
- R7: Each bit of the commit output equals the write-request bit of that lane AND the lane's active mask bit, in the same cycle.
- R8: A push while DEPTH entries are held changes neither the mask nor the stack. It sets the overflow flag, which stays set until reset.
- R9: A complement or pop while the stack is empty changes nothing. It sets the underflow flag, which stays set until reset.
- R10: Nested branches unwind in last-in first-out order over the full DEPTH levels.
- R11: Operation code 2'b00 leaves the mask and the stack unchanged, whatever the predicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Marker: 00 none, 01 push, 10 complement, 11 pop |
| pred_i | input | 32 | Per-lane branch predicate, sampled on push |
| wr_req_i | input | 32 | Per-lane writeback request |
| active_mask_o | output | 32 | Current active lane mask (registered) |
| commit_o | output | 32 | Writeback enables, request gated by mask |
| overflow_o | output | 1 | Sticky: push refused on a full stack |
| underflow_o | output | 1 | Sticky: complement or pop refused on an empty stack |

## Verification
A corrupted stack entry stays hidden until its branch is complemented or popped. It then shows on the active mask and the commit lanes at the edge that samples that marker. A skew in the stack pointer shows when a pop exposes the wrong parent mask. It also shows through a false or missing overflow or underflow flag at the depth boundary. The bench nests branches to the full depth and past it, and replays uniform and empty-stack cases. Every marker is compared one edge after it is applied, so a fault is seen in the cycle it first reaches the ports.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

    parameter int unsigned WARP_LANES = 32;
    parameter int unsigned NEST_DEPTH = 8;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PUSH  = 2'b01,
        OP_FLIP  = 2'b10,
        OP_POP   = 2'b11
    } mask_op_e;

    typedef struct packed {
        logic do_push;
        logic do_flip;
        logic do_pop;
        logic ovf_evt;
        logic unf_evt;
    } mask_cmd_t;

    function automatic mask_cmd_t decode_op(input mask_op_e op,
                                            input logic full,
                                            input logic empty);
        mask_cmd_t c;
        c = '0;
        unique case (op)
            OP_PUSH: begin
                c.do_push = !full;
                c.ovf_evt = full;
            end
            OP_FLIP: begin
                c.do_flip = !empty;
                c.unf_evt = empty;
            end
            OP_POP: begin
                c.do_pop  = !empty;
                c.unf_evt = empty;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simt_op_decode.sv
module simt_op_decode
    import simt_mask_pkg::*;
(
    input  logic [1:0] op_i,
    input  logic       full_i,
    input  logic       empty_i,
    output mask_cmd_t  cmd_o
);

    always_comb begin
        cmd_o = decode_op(mask_op_e'(op_i), full_i, empty_i);
    end

    always_comb begin
        assert_one_action_R11: assert ($onehot0({cmd_o.do_push, cmd_o.do_flip, cmd_o.do_pop,
                                               cmd_o.ovf_evt, cmd_o.unf_evt}));
    end

endmodule

// File: rtl/simt_mask_lifo.sv
module simt_mask_lifo #(
    parameter int unsigned LANES = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] wr_parent_i,
    input  logic [LANES-1:0] wr_taken_i,
    output logic [LANES-1:0] top_parent_o,
    output logic [LANES-1:0] top_taken_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int unsigned PW = $clog2(DEPTH + 1);

    logic [PW-1:0]                 count_q;
    logic [DEPTH-1:0][LANES-1:0]   par_flat;
    logic [DEPTH-1:0][LANES-1:0]   tak_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (push_i) begin
            count_q <= count_q + PW'(1);
        end else if (pop_i) begin
            count_q <= count_q - PW'(1);
        end
    end

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            logic [LANES-1:0] par_q;
            logic [LANES-1:0] tak_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    par_q <= '0;
                    tak_q <= '0;
                end else if (push_i && count_q == PW'(e)) begin
                    par_q <= wr_parent_i;
                    tak_q <= wr_taken_i;
                end
            end
            assign par_flat[e] = par_q;
            assign tak_flat[e] = tak_q;
        end
    endgenerate

    always_comb begin
        top_parent_o = '0;
        top_taken_o  = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (count_q == PW'(e + 1)) begin
                top_parent_o = par_flat[e];
                top_taken_o  = tak_flat[e];
            end
        end
    end

    assign full_o  = (count_q == PW'(DEPTH));
    assign empty_o = (count_q == '0);

    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
        count_q <= PW'(DEPTH));

    assert_full_push_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (full_o && !push_i && !pop_i) |=> full_o);

endmodule

// File: rtl/simt_div_mask.sv
module simt_div_mask
    import simt_mask_pkg::*;
#(
    parameter int unsigned LANES = WARP_LANES,
    parameter int unsigned DEPTH = NEST_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op_i,
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] wr_req_i,
    output logic [LANES-1:0] active_mask_o,
    output logic [LANES-1:0] commit_o,
    output logic             overflow_o,
    output logic             underflow_o
);

    mask_cmd_t        cmd;
    logic             full;
    logic             empty;
    logic [LANES-1:0] top_parent;
    logic [LANES-1:0] top_taken;
    logic [LANES-1:0] active_q;
    logic [LANES-1:0] active_d;
    logic [LANES-1:0] taken_new;
    logic             ovf_q;
    logic             unf_q;

    simt_op_decode u_decode (
        .op_i    (op_i),
        .full_i  (full),
        .empty_i (empty),
        .cmd_o   (cmd)
    );

    assign taken_new = active_q & pred_i;

    simt_mask_lifo #(
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) u_lifo (
        .clk          (clk),
        .rst          (rst),
        .push_i       (cmd.do_push),
        .pop_i        (cmd.do_pop),
        .wr_parent_i  (active_q),
        .wr_taken_i   (taken_new),
        .top_parent_o (top_parent),
        .top_taken_o  (top_taken),
        .full_o       (full),
        .empty_o      (empty)
    );

    always_comb begin
        active_d = active_q;
        if (cmd.do_push) begin
            active_d = taken_new;
        end else if (cmd.do_flip) begin
            active_d = top_parent & ~top_taken;
        end else if (cmd.do_pop) begin
            active_d = top_parent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '1;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            if (cmd.ovf_evt) ovf_q <= 1'b1;
            if (cmd.unf_evt) unf_q <= 1'b1;
        end
    end

    assign active_mask_o = active_q;
    assign commit_o      = wr_req_i & active_q;
    assign overflow_o    = ovf_q;
    assign underflow_o   = unf_q;

    assert_push_narrows_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b01) |=> ((active_mask_o & ~$past(active_mask_o)) == '0));

    assert_pop_widens_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b11 && !empty) |=> (($past(active_mask_o) & ~active_mask_o) == '0));

    assert_ovf_refused_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b01 && full) |=> (overflow_o && $stable(active_mask_o)));

    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> underflow_o);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (op_i == 2'b00) |=> $stable(active_mask_o));

endmodule

// File: tb/simt_div_mask_tb.sv
`timescale 1ns/1ps
module simt_div_mask_tb;

    localparam int LANES = 32;
    localparam int DEPTH = 8;

    typedef struct {
        logic [LANES-1:0] mask;
        logic [LANES-1:0] commit;
        logic             ovf;
        logic             unf;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       op_i = 2'b00;
    logic [LANES-1:0] pred_i = '0;
    logic [LANES-1:0] wr_req_i = '0;
    logic [LANES-1:0] active_mask_o;
    logic [LANES-1:0] commit_o;
    logic             overflow_o;
    logic             underflow_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    exp_t             sb_q[$];
    logic [LANES-1:0] m_mask;
    logic [LANES-1:0] m_par [DEPTH];
    logic [LANES-1:0] m_tak [DEPTH];
    int               m_sp;
    logic             m_ovf;
    logic             m_unf;

    always #2.5 clk = ~clk;

    simt_div_mask #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .op_i          (op_i),
        .pred_i        (pred_i),
        .wr_req_i      (wr_req_i),
        .active_mask_o (active_mask_o),
        .commit_o      (commit_o),
        .overflow_o    (overflow_o),
        .underflow_o   (underflow_o)
    );

    task automatic compare(input exp_t e);
        n_vec++;
        if (active_mask_o !== e.mask || commit_o !== e.commit ||
            overflow_o !== e.ovf || underflow_o !== e.unf) begin
            n_fail++;
            $display("FAIL %s: mask=%h commit=%h ovf=%b unf=%b, expected mask=%h commit=%h ovf=%b unf=%b",
                     e.req, active_mask_o, commit_o, overflow_o, underflow_o,
                     e.mask, e.commit, e.ovf, e.unf);
        end
    endtask

    // monitor: one comparison per applied vector, just after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    task automatic apply(input logic [1:0] op, input logic [LANES-1:0] pred,
                         input logic [LANES-1:0] wr, input string req);
        exp_t e;
        @(negedge clk);
        op_i = op; pred_i = pred; wr_req_i = wr;
        case (op)
            2'b01: if (m_sp == DEPTH) m_ovf = 1'b1;
                   else begin
                       m_par[m_sp] = m_mask;
                       m_tak[m_sp] = m_mask & pred;
                       m_mask = m_mask & pred;
                       m_sp++;
                   end
            2'b10: if (m_sp == 0) m_unf = 1'b1;
                   else m_mask = m_par[m_sp-1] & ~m_tak[m_sp-1];
            2'b11: if (m_sp == 0) m_unf = 1'b1;
                   else begin
                       m_sp--;
                       m_mask = m_par[m_sp];
                   end
            default: ;
        endcase
        e.mask = m_mask; e.commit = wr & m_mask;
        e.ovf = m_ovf; e.unf = m_unf; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic do_reset();
        exp_t e;
        wait (sb_q.size() == 0);
        @(negedge clk);
        rst = 1'b1; op_i = 2'b00; wr_req_i = 32'hA5A5_0F0F;
        m_mask = '1; m_sp = 0; m_ovf = 1'b0; m_unf = 1'b0;
        @(posedge clk);
        #1;
        e.mask = '1; e.commit = 32'hA5A5_0F0F; e.ovf = 1'b0; e.unf = 1'b0; e.req = "R1";
        compare(e);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        m_mask = '1; m_sp = 0; m_ovf = 1'b0; m_unf = 1'b0;
        repeat (2) @(posedge clk);
        do_reset();

        // R11: idle with arbitrary predicate; R7 commit gating
        apply(2'b00, 32'h1234_5678, 32'hFFFF_FFFF, "R11");
        apply(2'b00, 32'h0000_0000, 32'h0F0F_00FF, "R7");

        // R2/R4/R5 single branch
        apply(2'b01, 32'h0000_FFFF, 32'hFFFF_FFFF, "R2");
        apply(2'b10, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R4");
        apply(2'b10, 32'h0000_0000, 32'h00FF_FF00, "R4");
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R5");

        // R3/R10 nested branches with inactive lanes in the parent
        apply(2'b01, 32'hF0F0_F0F0, 32'hFFFF_FFFF, "R2");
        apply(2'b01, 32'h3333_FFFF, 32'hFFFF_FFFF, "R3");
        apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, "R4");
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R10");
        apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, "R10");
        apply(2'b01, 32'hFFFF_0000, 32'h1111_1111, "R3");
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R10");
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R5");

        // R6 uniform predicates
        apply(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
        apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, "R6");
        apply(2'b01, 32'h0000_0000, 32'hFFFF_FFFF, "R6");
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R6");
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R6");

        // R10 full depth, R8 overflow refused
        for (int k = 0; k < DEPTH; k++) begin
            apply(2'b01, ~(32'h1 << (k * 3)), 32'hFFFF_FFFF, "R10");
        end
        apply(2'b01, 32'h0000_0000, 32'hFFFF_FFFF, "R8");
        apply(2'b00, 32'h0000_0000, 32'hFFFF_FFFF, "R8");
        apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, "R8");
        for (int k = 0; k < DEPTH; k++) begin
            apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R10");
        end

        // R9 underflow on an empty stack
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R9");
        apply(2'b10, 32'h0000_0000, 32'hFFFF_FFFF, "R9");
        apply(2'b01, 32'h00FF_00FF, 32'hFFFF_FFFF, "R9");
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R9");

        // R1 reset clears flags and stack
        apply(2'b01, 32'h0000_000F, 32'hFFFF_FFFF, "R2");
        do_reset();
        apply(2'b11, 32'h0000_0000, 32'hFFFF_FFFF, "R1");

        @(negedge clk);
        op_i = 2'b00;
        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule